// File: doc/BRIEF.md
# Multiplexed Host Bus Cycle Decoder

This block sits between an external host and a memory-side data path. The host uses a single bus for both addresses and data. The block turns the host's chip select and two data strobes into one internal transfer strobe, and it works out the cycle type from the access-select, direction and halfword pins. In the narrow mode it pairs two 16-bit halfwords into one 32-bit word. It then sends each complete word to one of three places: a small control register, one of two address registers, or the data path toward memory. Each data transfer is given the address held in the matching address register. That register can advance by one word after the transfer.

The cycle type is captured at one of two moments. When the host pulses the address latch enable, the type is captured on that falling edge. When the host ties the address latch enable high, the type is captured when the strobe starts. The block keeps separate read and write address registers. Bit 0 of the control register selects whether an address load goes to both registers or to only one of them. The memory side is modelled by a read-word input and a write-strobe output, so all host-visible effects can be observed at the ports. All pins are sampled on the block clock, and a host transfer is expected to last several clock cycles.

Top module: `hbus_cycle_decoder`

## Requirements
- R1: A transfer is active only while `cs_n` is low and exactly one of `ds_a_n`/`ds_b_n` is low. With both data strobes low, or with `cs_n` high, the stimulus has no effect: no write strobe is produced and the address registers are unchanged.
- R2: `acc_sel`, `host_rnw` and `hw_second` are captured on a falling edge of `ale_n`. When `ale_n` has not fallen since the previous transfer ended, they are captured at the start of the strobe instead. Pin changes after the capture point do not alter the cycle.
- R3: `acc_sel` decodes as follows: 00 is the control register, 01 is data with autoincrement, 10 is the address registers, and 11 is data with no increment.
- R4: When `wide_mode`=0, a data or address word is built from two transfers. The first has `hw_second`=0 and supplies bits 15:0. The second has `hw_second`=1 and supplies bits 31:16. The word is committed at the end of the second transfer.
- R5: A control access needs a single transfer in either mode. A write loads `hd_in[15:0]`. A read returns the 16-bit register on both halves of `hd_out`.
- R6: When control bit 0 is 0 (single mode, the reset value), an address word loads both the write and the read address registers.
- R7: When control bit 0 is 1 (dual mode), an address word with `host_rnw`=0 loads only the write address register, and one with `host_rnw`=1 loads only the read address register.
- R8: After a committed data word with `acc_sel`=01, the matching address register grows by 4. With 11 it stays the same. A write is reported on `wr_stb` with the address from before the increment.
- R9: If the second halfword's access type or direction differs from the first halfword's, the word is dropped. No strobe is produced and no register changes.
- R10: When `wide_mode`=1, each transfer carries a full 32-bit word and commits on its own. `hw_second` is ignored.
- R11: After reset the address registers and the control register are 0, and `wr_stb`, `rd_done` and `hd_oe` are low.
- R12: During a read transfer of control or data, `hd_oe` is high. On a narrow data read, `hd_out[15:0]` carries the low half of `rd_word` for the first transfer and the high half for the second. `rd_done` pulses when the read word completes. `hd_oe` stays low for writes and for address accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: 32-bit transfers, 0: paired 16-bit halfwords |
| cs_n | input | 1 | Host chip select, active low |
| ds_a_n | input | 1 | Host data strobe A, active low |
| ds_b_n | input | 1 | Host data strobe B, active low |
| ale_n | input | 1 | Address latch enable, active low; tie high if unused |
| acc_sel | input | 2 | Access type select |
| host_rnw | input | 1 | 1 = read, 0 = write |
| hw_second | input | 1 | 0 = first halfword, 1 = second halfword |
| hd_in | input | 32 | Host data bus, inbound |
| hd_out | output | 32 | Host data bus, outbound |
| hd_oe | output | 1 | Drive enable for `hd_out` |
| rd_word | input | 32 | Memory word at `rd_addr_cur` |
| wr_addr_cur | output | 32 | Write address register |
| rd_addr_cur | output | 32 | Read address register |
| wr_stb | output | 1 | One-cycle pulse for a committed data write |
| wr_stb_addr | output | 32 | Address of the committed write |
| wr_stb_data | output | 32 | Data of the committed write |
| rd_done | output | 1 | One-cycle pulse when a read word completes |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, 16-bit halves, and an increment step of 4. With these values, halfword pairing and the exact expected address arithmetic can be checked directly. A vector table runs in narrow mode and covers the following cases:
- address loads in single mode and in dual mode
- incrementing and non-incrementing reads and writes
- a mismatched halfword pair
- control writes and reads
- cycles framed by the address latch enable, with the select pins deliberately changed after the latch point

Directed tests then cover illegal strobe combinations, the alternate data strobe, and 32-bit mode transfers, including the mirrored control readback.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    ACC_CTRL     = 2'b00,
    ACC_DATA_INC = 2'b01,
    ACC_ADDR     = 2'b10,
    ACC_DATA_FIX = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e sel;
    logic rnw;
    logic hw;
  } cyc_t;
endpackage

// File: rtl/hbus_cycle_latch.sv
module hbus_cycle_latch
  import hbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic ds_a_n,
  input  logic ds_b_n,
  input  logic ale_n,
  input  logic [1:0] acc_sel,
  input  logic host_rnw,
  input  logic hw_second,
  output logic strb_act,
  output logic strb_start,
  output logic strb_end,
  output cyc_t cyc
);
  logic strb_now;
  logic strb_q;
  logic ale_q, ale_fall;
  logic seen_q, seen_d;
  cyc_t cyc_q, cyc_d, pin_cyc;

  // internal strobe: chip selected and exactly one data strobe low
  assign strb_now   = ~cs_n & (ds_a_n ^ ds_b_n);
  assign strb_start = strb_now & ~strb_q;
  assign strb_end   = ~strb_now & strb_q;
  assign strb_act   = strb_now & strb_q;
  assign ale_fall   = ale_q & ~ale_n;
  assign pin_cyc    = '{sel: acc_e'(acc_sel), rnw: host_rnw, hw: hw_second};
  assign cyc        = cyc_q;

  always_comb begin
    cyc_d  = cyc_q;
    seen_d = seen_q;
    if (ale_fall) begin
      cyc_d  = pin_cyc;
      seen_d = 1'b1;
    end else begin
      if (strb_start && !seen_q) cyc_d = pin_cyc;
      if (strb_end) seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      ale_q  <= 1'b1;
      seen_q <= 1'b0;
      cyc_q  <= '{sel: ACC_CTRL, rnw: 1'b0, hw: 1'b0};
    end else begin
      strb_q <= strb_now;
      ale_q  <= ale_n;
      seen_q <= seen_d;
      cyc_q  <= cyc_d;
    end
  end

  assert_ale_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_fall |=> (cyc_q == $past(pin_cyc)));
  assert_strobe_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_start && !seen_q && !ale_fall) |=> (cyc_q == $past(pin_cyc)));
endmodule

// File: rtl/hbus_hw_pack.sv
module hbus_hw_pack
  import hbus_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic          strb_end,
  input  cyc_t          cyc,
  input  logic [DW-1:0] hd_in,
  output logic          word_ok,
  output logic [DW-1:0] word_val
);
  localparam int HW = DW / 2;

  logic          have_q, have_d;
  logic [HW-1:0] half_q, half_d;
  acc_e          fsel_q, fsel_d;
  logic          frnw_q, frnw_d;
  logic          match;

  assign match = have_q && (fsel_q == cyc.sel) && (frnw_q == cyc.rnw);

  always_comb begin
    have_d   = have_q;
    half_d   = half_q;
    fsel_d   = fsel_q;
    frnw_d   = frnw_q;
    word_ok  = 1'b0;
    word_val = hd_in;
    if (wide) begin
      word_ok = strb_end;
      if (strb_end) have_d = 1'b0;
    end else if (cyc.sel == ACC_CTRL) begin
      word_ok  = strb_end;
      word_val = {2{hd_in[HW-1:0]}};
    end else if (!cyc.hw) begin
      word_val = {hd_in[HW-1:0], half_q};
      if (strb_end) begin
        have_d = 1'b1;
        half_d = hd_in[HW-1:0];
        fsel_d = cyc.sel;
        frnw_d = cyc.rnw;
      end
    end else begin
      word_val = {hd_in[HW-1:0], half_q};
      word_ok  = strb_end & match;
      if (strb_end) have_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      half_q <= '0;
      fsel_q <= ACC_CTRL;
      frnw_q <= 1'b0;
    end else begin
      have_q <= have_d;
      half_q <= half_d;
      fsel_q <= fsel_d;
      frnw_q <= frnw_d;
    end
  end

  assert_pair_needs_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && !wide && cyc.sel != ACC_CTRL) |-> have_q);
  assert_mismatch_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_end && !wide && cyc.sel != ACC_CTRL && cyc.hw && !match) |=> !have_q);
endmodule

// File: rtl/hbus_addr_regs.sv
module hbus_addr_regs #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          ld_rnw,
  input  logic          dual,
  input  logic [AW-1:0] ld_val,
  input  logic          wr_inc,
  input  logic          rd_inc,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] wa_q, wa_d, ra_q, ra_d;

  always_comb begin
    wa_d = wa_q;
    ra_d = ra_q;
    if (ld) begin
      if (!dual || !ld_rnw) wa_d = ld_val;
      if (!dual ||  ld_rnw) ra_d = ld_val;
    end
    if (wr_inc) wa_d = wa_q + STEP_V;
    if (rd_inc) ra_d = ra_q + STEP_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_q <= '0;
      ra_q <= '0;
    end else begin
      wa_q <= wa_d;
      ra_q <= ra_d;
    end
  end

  assign waddr = wa_q;
  assign raddr = ra_q;

  assert_single_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !dual) |=> (wa_q == ra_q) && (wa_q == $past(ld_val)));
  assert_dual_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && dual && ld_rnw && !wr_inc) |=> (wa_q == $past(wa_q)));
  assert_autoinc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inc && !ld) |=> (wa_q == $past(wa_q) + STEP_V));
endmodule

// File: rtl/hbus_cycle_decoder.sv
module hbus_cycle_decoder
  import hbus_pkg::*;
#(
  parameter int DW       = 32,
  parameter int STEP     = 4,
  parameter int DUAL_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic          cs_n,
  input  logic          ds_a_n,
  input  logic          ds_b_n,
  input  logic          ale_n,
  input  logic [1:0]    acc_sel,
  input  logic          host_rnw,
  input  logic          hw_second,
  input  logic [DW-1:0] hd_in,
  output logic [DW-1:0] hd_out,
  output logic          hd_oe,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] wr_addr_cur,
  output logic [DW-1:0] rd_addr_cur,
  output logic          wr_stb,
  output logic [DW-1:0] wr_stb_addr,
  output logic [DW-1:0] wr_stb_data,
  output logic          rd_done
);
  localparam int HW = DW / 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  logic strb_act, strb_start, strb_end;
  cyc_t cyc;

  hbus_cycle_latch u_latch (
    .clk, .rst_n(rst_i_n), .cs_n, .ds_a_n, .ds_b_n, .ale_n,
    .acc_sel, .host_rnw, .hw_second,
    .strb_act, .strb_start, .strb_end, .cyc
  );

  logic          word_ok;
  logic [DW-1:0] word_val;

  hbus_hw_pack #(.DW(DW)) u_pack (
    .clk, .rst_n(rst_i_n), .wide(wide_mode), .strb_end, .cyc, .hd_in,
    .word_ok, .word_val
  );

  logic is_data, ld, ctrl_we, wcommit, rcommit, wr_inc, rd_inc, dual;
  logic [HW-1:0] ctrl_q, ctrl_d;

  assign is_data = (cyc.sel == ACC_DATA_INC) || (cyc.sel == ACC_DATA_FIX);
  assign ld      = word_ok && (cyc.sel == ACC_ADDR);
  assign ctrl_we = word_ok && (cyc.sel == ACC_CTRL) && !cyc.rnw;
  assign wcommit = word_ok && is_data && !cyc.rnw;
  assign rcommit = word_ok && is_data &&  cyc.rnw;
  assign wr_inc  = wcommit && (cyc.sel == ACC_DATA_INC);
  assign rd_inc  = rcommit && (cyc.sel == ACC_DATA_INC);
  assign dual    = ctrl_q[DUAL_BIT];

  hbus_addr_regs #(.AW(DW), .STEP(STEP)) u_addr (
    .clk, .rst_n(rst_i_n), .ld, .ld_rnw(cyc.rnw), .dual, .ld_val(word_val),
    .wr_inc, .rd_inc, .waddr(wr_addr_cur), .raddr(rd_addr_cur)
  );

  // control register and commit strobes
  logic          wstb_q, wstb_d, rdn_q, rdn_d;
  logic [DW-1:0] wsa_q, wsa_d, wsd_q, wsd_d;

  always_comb begin
    ctrl_d = ctrl_q;
    wstb_d = wcommit;
    rdn_d  = rcommit;
    wsa_d  = wsa_q;
    wsd_d  = wsd_q;
    if (ctrl_we) ctrl_d = word_val[HW-1:0];
    if (wcommit) begin
      wsa_d = wr_addr_cur;
      wsd_d = word_val;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q <= '0;
      wstb_q <= 1'b0;
      rdn_q  <= 1'b0;
      wsa_q  <= '0;
      wsd_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      wstb_q <= wstb_d;
      rdn_q  <= rdn_d;
      wsa_q  <= wsa_d;
      wsd_q  <= wsd_d;
    end
  end

  assign wr_stb      = wstb_q;
  assign wr_stb_addr = wsa_q;
  assign wr_stb_data = wsd_q;
  assign rd_done     = rdn_q;

  // outbound data steering
  always_comb begin
    hd_out = '0;
    unique case (cyc.sel)
      ACC_CTRL: hd_out = {2{ctrl_q}};
      ACC_ADDR: hd_out = '0;
      default: begin
        if (wide_mode)   hd_out = rd_word;
        else if (cyc.hw) hd_out = {{HW{1'b0}}, rd_word[DW-1:HW]};
        else             hd_out = {{HW{1'b0}}, rd_word[HW-1:0]};
      end
    endcase
  end
  assign hd_oe = strb_act && cyc.rnw && (cyc.sel != ACC_ADDR);

  assert_oe_needs_select_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    hd_oe |-> !cs_n);
  assert_wr_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_stb |=> !wr_stb);
  assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(wr_stb && rd_done));
endmodule

// File: tb/tb_hbus_cycle_decoder.sv
module tb_hbus_cycle_decoder;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, wide_mode, cs_n, ds_a_n, ds_b_n, ale_n, host_rnw, hw_second;
  logic [1:0]  acc_sel;
  logic [31:0] hd_in, hd_out, rd_word, wr_addr_cur, rd_addr_cur, wr_stb_addr, wr_stb_data;
  logic        hd_oe, wr_stb, rd_done;

  hbus_cycle_decoder dut (
    .clk, .rst_n, .wide_mode, .cs_n, .ds_a_n, .ds_b_n, .ale_n, .acc_sel,
    .host_rnw, .hw_second, .hd_in, .hd_out, .hd_oe, .rd_word,
    .wr_addr_cur, .rd_addr_cur, .wr_stb, .wr_stb_addr, .wr_stb_data, .rd_done
  );

  // memory model: word derived from the read address
  assign rd_word = {rd_addr_cur[15:0] ^ 16'hC3C3, rd_addr_cur[15:0]};

  int n_chk = 0, n_fail = 0;
  int ev_wr = 0, ev_rd = 0;
  logic [31:0] last_wa, last_wd;

  always @(negedge clk) begin
    if (wr_stb) begin ev_wr++; last_wa = wr_stb_addr; last_wd = wr_stb_data; end
    if (rd_done) ev_rd++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // smode: 0 strobe A, 1 strobe B, 2 both strobes, 3 chip select high
  task automatic xfer(input logic [1:0] s, input logic r, input logic h, input logic a,
                      input logic [1:0] sm, input logic [31:0] d,
                      output logic [31:0] hdv, output logic oev);
    ev_wr = 0; ev_rd = 0;
    acc_sel = s; host_rnw = r; hw_second = h; hd_in = d;
    if (a) begin
      ale_n = 1'b0; @(negedge clk);
      ale_n = 1'b1; @(negedge clk);
      acc_sel = ~s; host_rnw = ~r; hw_second = ~h;
    end
    case (sm)
      2'd0: begin cs_n = 1'b0; ds_a_n = 1'b0; end
      2'd1: begin cs_n = 1'b0; ds_b_n = 1'b0; end
      2'd2: begin cs_n = 1'b0; ds_a_n = 1'b0; ds_b_n = 1'b0; end
      default: begin cs_n = 1'b1; ds_a_n = 1'b0; end
    endcase
    repeat (2) @(negedge clk);
    hdv = hd_out; oev = hd_oe;
    @(negedge clk);
    cs_n = 1'b1; ds_a_n = 1'b1; ds_b_n = 1'b1;
    repeat (3) @(negedge clk);
    acc_sel = s; host_rnw = r; hw_second = h;
  endtask

  typedef struct packed {
    logic [1:0]  sel;
    logic        rnw;
    logic        hw;
    logic        ale;
    logic [15:0] din;
    logic [1:0]  ev;     // 0 none, 1 write strobe, 2 read done
    logic [31:0] word;
    logic [31:0] evaddr;
    logic [31:0] wa;
    logic [31:0] ra;
    logic [15:0] hd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VT [NV] = '{
    '{2'b10,1'b0,1'b0,1'b0,16'h1000,2'd0,32'h0,32'h0,32'h0000,32'h0000,16'h0},      // R4 first half
    '{2'b10,1'b0,1'b1,1'b0,16'h0000,2'd0,32'h0,32'h0,32'h1000,32'h1000,16'h0},      // R6 single load
    '{2'b01,1'b0,1'b0,1'b0,16'hBEEF,2'd0,32'h0,32'h0,32'h1000,32'h1000,16'h0},
    '{2'b01,1'b0,1'b1,1'b0,16'hDEAD,2'd1,32'hDEADBEEF,32'h1000,32'h1004,32'h1000,16'h0}, // R8 inc
    '{2'b11,1'b0,1'b0,1'b0,16'h1111,2'd0,32'h0,32'h0,32'h1004,32'h1000,16'h0},
    '{2'b11,1'b0,1'b1,1'b0,16'h2222,2'd1,32'h22221111,32'h1004,32'h1004,32'h1000,16'h0}, // R8 fixed
    '{2'b01,1'b1,1'b0,1'b0,16'h0000,2'd0,32'h0,32'h0,32'h1004,32'h1000,16'h1000},   // R12 low half
    '{2'b01,1'b1,1'b1,1'b0,16'h0000,2'd2,32'h0,32'h0,32'h1004,32'h1004,16'hD3C3},   // R12 high half
    '{2'b11,1'b1,1'b0,1'b0,16'h0000,2'd0,32'h0,32'h0,32'h1004,32'h1004,16'h1004},
    '{2'b11,1'b1,1'b1,1'b0,16'h0000,2'd2,32'h0,32'h0,32'h1004,32'h1004,16'hD3C7},
    '{2'b11,1'b0,1'b0,1'b0,16'h3333,2'd0,32'h0,32'h0,32'h1004,32'h1004,16'h0},      // R9 first
    '{2'b01,1'b0,1'b1,1'b0,16'h4444,2'd0,32'h0,32'h0,32'h1004,32'h1004,16'h0},      // R9 dropped
    '{2'b00,1'b0,1'b0,1'b0,16'h0001,2'd0,32'h0,32'h0,32'h1004,32'h1004,16'h0},      // R5 dual on
    '{2'b00,1'b1,1'b0,1'b0,16'h0000,2'd0,32'h0,32'h0,32'h1004,32'h1004,16'h0001},   // R5 read
    '{2'b10,1'b1,1'b0,1'b0,16'h2000,2'd0,32'h0,32'h0,32'h1004,32'h1004,16'h0},      // R7
    '{2'b10,1'b1,1'b1,1'b0,16'h0000,2'd0,32'h0,32'h0,32'h1004,32'h2000,16'h0},
    '{2'b10,1'b0,1'b0,1'b0,16'h3000,2'd0,32'h0,32'h0,32'h1004,32'h2000,16'h0},
    '{2'b10,1'b0,1'b1,1'b0,16'h0000,2'd0,32'h0,32'h0,32'h3000,32'h2000,16'h0},
    '{2'b01,1'b0,1'b0,1'b1,16'h5555,2'd0,32'h0,32'h0,32'h3000,32'h2000,16'h0},      // R2 latch
    '{2'b01,1'b0,1'b1,1'b1,16'h6666,2'd1,32'h66665555,32'h3000,32'h3004,32'h2000,16'h0}
  };

  initial begin
    #200_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] hdv;
    logic        oev;
    rst_n = 1'b0; wide_mode = 1'b0; cs_n = 1'b1; ds_a_n = 1'b1; ds_b_n = 1'b1;
    ale_n = 1'b1; acc_sel = 2'b00; host_rnw = 1'b0; hw_second = 1'b0; hd_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 write address", wr_addr_cur, 32'h0);
    chk("R11 read address", rd_addr_cur, 32'h0);
    chk("R11 wr_stb", {31'h0, wr_stb}, 32'h0);
    chk("R11 rd_done", {31'h0, rd_done}, 32'h0);
    chk("R11 hd_oe", {31'h0, hd_oe}, 32'h0);

    // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R12
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VT[i];
      xfer(v.sel, v.rnw, v.hw, v.ale, 2'd0, {16'h0, v.din}, hdv, oev);
      chk("R3/R4 write strobe count", ev_wr, (v.ev == 2'd1) ? 1 : 0);
      chk("R12 read done count", ev_rd, (v.ev == 2'd2) ? 1 : 0);
      if (v.ev == 2'd1) begin
        chk("R4 committed data", last_wd, v.word);
        chk("R8 committed address", last_wa, v.evaddr);
      end
      chk("R6/R7/R8 write address", wr_addr_cur, v.wa);
      chk("R6/R7/R8 read address", rd_addr_cur, v.ra);
      if (v.rnw && v.sel != 2'b10) begin
        chk("R12 drive enable on read", {31'h0, oev}, 32'h1);
        chk("R12 read halfword", {16'h0, hdv[15:0]}, {16'h0, v.hd});
      end else begin
        chk("R12 no drive on write/address", {31'h0, oev}, 32'h0);
      end
    end

    // R1 both data strobes low: ignored
    xfer(2'b11, 1'b0, 1'b0, 1'b0, 2'd2, 32'h0000_9999, hdv, oev);
    xfer(2'b11, 1'b0, 1'b1, 1'b0, 2'd2, 32'h0000_AAAA, hdv, oev);
    chk("R1 both strobes no write", ev_wr, 0);
    chk("R1 both strobes address kept", wr_addr_cur, 32'h3004);
    // R1 chip select high: ignored
    xfer(2'b01, 1'b0, 1'b0, 1'b0, 2'd3, 32'h0000_9999, hdv, oev);
    xfer(2'b01, 1'b0, 1'b1, 1'b0, 2'd3, 32'h0000_AAAA, hdv, oev);
    chk("R1 deselected no write", ev_wr, 0);
    chk("R1 deselected address kept", wr_addr_cur, 32'h3004);
    // R1 strobe B alone is valid
    xfer(2'b11, 1'b0, 1'b0, 1'b0, 2'd1, 32'h0000_7777, hdv, oev);
    xfer(2'b11, 1'b0, 1'b1, 1'b0, 2'd1, 32'h0000_8888, hdv, oev);
    chk("R1 strobe B write", ev_wr, 1);
    chk("R1 strobe B data", last_wd, 32'h8888_7777);

    // R10 wide mode: one transfer per word, hw_second ignored
    wide_mode = 1'b1;
    xfer(2'b11, 1'b0, 1'b1, 1'b0, 2'd0, 32'hCAFE_F00D, hdv, oev);
    chk("R10 wide write count", ev_wr, 1);
    chk("R10 wide write data", last_wd, 32'hCAFE_F00D);
    chk("R10 wide write address", last_wa, 32'h3004);
    // R5 control write in wide mode returns to single mode
    xfer(2'b00, 1'b0, 1'b0, 1'b0, 2'd0, 32'h1234_00F0, hdv, oev);
    // R6 single-mode address load in wide mode
    xfer(2'b10, 1'b0, 1'b0, 1'b0, 2'd0, 32'h4000_0000, hdv, oev);
    chk("R6 wide load write address", wr_addr_cur, 32'h4000_0000);
    chk("R6 wide load read address", rd_addr_cur, 32'h4000_0000);
    // R5 mirrored control readback
    xfer(2'b00, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0, hdv, oev);
    chk("R5 control mirrored", hdv, 32'h00F0_00F0);
    // R12 wide data read with increment
    xfer(2'b01, 1'b1, 1'b0, 1'b0, 2'd0, 32'h0, hdv, oev);
    chk("R12 wide read data", hdv, 32'hC3C3_0000);
    chk("R12 wide read done", ev_rd, 1);
    chk("R8 read address increment", rd_addr_cur, 32'h4000_0004);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule